// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is a narrow host access port that gives a processor reach into a 64 KB byte-addressed internal space through a window of only four byte locations. The host writes a 16-bit pointer, then moves bytes through a single data location. With auto-step enabled, the pointer advances after every data access, so a block of consecutive bytes can be streamed without rewriting the pointer.

The internal side is a plain byte port: an address, a read strobe, a write strobe and write data, with read data returned in the same cycle. A mode byte at window offset 0 is always reachable. It holds the control bits, including a software reset bit that runs an internal reset of fixed length and then clears itself. The host-side sequence is to write the reset bit, wait, and then write mode 0x13 to enable ping blocking, auto-step and pointer access together.

Top module: `idx_access_bridge`

## Requirements
- R1: The window uses offset 0 for the mode byte, offset 1 for the pointer high byte, offset 2 for the pointer low byte and offset 3 for data. The mode byte reads back bit 4 (ping block), bit 1 (auto-step) and bit 0 (pointer access) as written, bit 7 as the reset-in-progress flag, and every other bit as 0.
- R2: After rst_ni is released, the mode byte reads 0x00, the pointer is 0x0000, and soft_rst_o and ping_block_o are low.
- R3: A write to offset 1 sets pointer bits 15:8 and a write to offset 2 sets bits 7:0. Both read back at their own offsets.
- R4: A host write to offset 3 raises mem_we_o in that same cycle, with mem_addr_o equal to the pointer and mem_wdata_o equal to the host byte.
- R5: A host read of offset 3 raises mem_re_o in that same cycle with mem_addr_o equal to the pointer, and host_rdata_o returns mem_rdata_i combinationally.
- R6: With mode bit 1 set, each data access moves the pointer up by one from the next cycle on. Consecutive data reads therefore return consecutive internal bytes.
- R7: With mode bit 1 clear, the pointer keeps its value across data accesses.
- R8: The pointer wraps from 0xFFFF to 0x0000 when it steps.
- R9: While mode bit 0 is clear, offsets 1 to 3 read as 0x00, writes to them are ignored, and no memory strobe is raised. The mode byte stays fully accessible.
- R10: Writing the mode byte with bit 7 set raises soft_rst_o for RST_CYCLES cycles, starting in the cycle after the write. During that time the mode byte reads 0x80 and the pointer is cleared. Afterwards the mode byte reads 0x00.
- R11: While a software reset is in progress, host writes to every offset are ignored.
- R12: ping_block_o follows mode bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host access in this cycle |
| host_wr_i | input | 1 | 1 for write, 0 for read |
| host_off_i | input | 2 | Window offset |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte |
| mem_addr_o | output | ADDR_W | Internal byte address (pointer) |
| mem_re_o | output | 1 | Internal read strobe |
| mem_we_o | output | 1 | Internal write strobe |
| mem_wdata_o | output | 8 | Internal write byte |
| mem_rdata_i | input | 8 | Internal read byte, same cycle |
| soft_rst_o | output | 1 | Software reset in progress |
| ping_block_o | output | 1 | Ping block control bit |

## Verification
The bench sweeps streaming reads over 256 addresses and streaming writes over 64 addresses. Every byte is checked against an arithmetic pattern of its address, so a pointer that stepped late, twice, or when auto-step was off would return a shifted pattern. It crosses the 0xFFFF boundary, where a pointer that saturated or carried into a wider register would report the wrong address. It also hits the reset window with mode writes, and checks exactly how many cycles soft_rst_o stays high. A design that let writes through, kept the old bits, or miscounted the window would read back something other than 0x80, then 0x00. Finally it checks that, with pointer access off, pointer writes leave no trace and data accesses raise no strobe.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  typedef enum logic [1:0] {
    OFF_MODE = 2'd0,
    OFF_PHI  = 2'd1,
    OFF_PLO  = 2'd2,
    OFF_DATA = 2'd3
  } host_off_e;

  localparam int unsigned MB_RST = 7;
  localparam int unsigned MB_PB  = 4;
  localparam int unsigned MB_AI  = 1;
  localparam int unsigned MB_IND = 0;
endpackage

// File: rtl/ibr_mode_reg.sv
module ibr_mode_reg #(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       pb_o,
  output logic       ai_o,
  output logic       ind_o,
  output logic [7:0] rd_o
);
  import ibr_pkg::*;
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(RST_CYCLES - 1);

  logic          busy_q, pb_q, ai_q, ind_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pb_q   <= 1'b0;
      ai_q   <= 1'b0;
      ind_q  <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (wr_i) begin
      if (wdata_i[MB_RST]) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_INIT;
        pb_q   <= 1'b0;
        ai_q   <= 1'b0;
        ind_q  <= 1'b0;
      end else begin
        pb_q  <= wdata_i[MB_PB];
        ai_q  <= wdata_i[MB_AI];
        ind_q <= wdata_i[MB_IND];
      end
    end
  end

  assign busy_o = busy_q;
  assign pb_o   = pb_q;
  assign ai_o   = ai_q;
  assign ind_o  = ind_q;
  assign rd_o   = {busy_q, 2'b00, pb_q, 2'b00, ai_q, ind_q};

  // R10: control bits stay cleared for the whole reset window
  a_r10_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !(pb_q || ai_q || ind_q));
  // R10: the window does not end before the count runs out
  a_r10_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
  // R11: a mode write during reset changes no control bit
  a_r11_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(pb_q) && $stable(ai_q) && $stable(ind_q));
endmodule

// File: rtl/ibr_addr_reg.sv
module ibr_addr_reg #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [7:0]        wdata_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (clr_i)    addr_q <= '0;
    else if (wr_hi_i)  addr_q[ADDR_W-1:8] <= wdata_i[HI_W-1:0];
    else if (wr_lo_i)  addr_q[7:0] <= wdata_i;
    else if (step_i)   addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;

  // R6: a stepped access advances by exactly one
  a_r6_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && !wr_hi_i && !wr_lo_i) |=> addr_q == $past(addr_q) + 1'b1);
  // R8: stepping from the top wraps to zero
  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && !wr_hi_i && !wr_lo_i && (&addr_q)) |=> addr_q == '0);
  // R7: no step and no write leaves the pointer alone
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i && !wr_hi_i && !wr_lo_i) |=> $stable(addr_q));
endmodule

// File: rtl/ibr_host_port.sv
module ibr_host_port #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [1:0]        off_i,
  input  logic [7:0]        mode_rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic              ind_i,
  input  logic              ai_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              wr_mode_o,
  output logic              wr_hi_o,
  output logic              wr_lo_o,
  output logic              step_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [7:0]        rdata_o
);
  import ibr_pkg::*;

  host_off_e off;
  logic      acc, ind_acc;

  assign off     = host_off_e'(off_i);
  assign acc     = sel_i && !busy_i;
  assign ind_acc = acc && ind_i;

  assign wr_mode_o = acc && wr_i && off == OFF_MODE;
  assign wr_hi_o   = ind_acc && wr_i && off == OFF_PHI;
  assign wr_lo_o   = ind_acc && wr_i && off == OFF_PLO;
  assign mem_we_o  = ind_acc && wr_i && off == OFF_DATA;
  assign mem_re_o  = ind_acc && !wr_i && off == OFF_DATA;
  assign step_o    = (mem_we_o || mem_re_o) && ai_i;

  always_comb begin
    rdata_o = 8'h00;
    if (sel_i && !wr_i) begin
      unique case (off)
        OFF_MODE: rdata_o = mode_rd_i;
        OFF_PHI:  rdata_o = ind_i ? 8'(addr_i[ADDR_W-1:8]) : 8'h00;
        OFF_PLO:  rdata_o = ind_i ? addr_i[7:0] : 8'h00;
        OFF_DATA: rdata_o = mem_re_o ? mem_rdata_i : 8'h00;
        default:  rdata_o = 8'h00;
      endcase
    end
  end

  // R9/R11: internal strobes only with pointer access on and no reset running
  a_r9_strobe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> (ind_i && !busy_i));
  // R4/R5: never read and write at once
  a_r4_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

// File: rtl/idx_access_bridge.sv
module idx_access_bridge #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_i,
  input  logic              host_wr_i,
  input  logic [1:0]        host_off_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              soft_rst_o,
  output logic              ping_block_o
);
  logic       busy, pb, ai, ind;
  logic       wr_mode, wr_hi, wr_lo, step;
  logic [7:0] mode_rd;
  logic [ADDR_W-1:0] addr;

  ibr_mode_reg #(.RST_CYCLES(RST_CYCLES)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_mode),
    .wdata_i (host_wdata_i),
    .busy_o  (busy),
    .pb_o    (pb),
    .ai_o    (ai),
    .ind_o   (ind),
    .rd_o    (mode_rd)
  );

  ibr_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (busy),
    .wr_hi_i (wr_hi),
    .wr_lo_i (wr_lo),
    .wdata_i (host_wdata_i),
    .step_i  (step),
    .addr_o  (addr)
  );

  ibr_host_port #(.ADDR_W(ADDR_W)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (host_sel_i),
    .wr_i        (host_wr_i),
    .off_i       (host_off_i),
    .mode_rd_i   (mode_rd),
    .addr_i      (addr),
    .busy_i      (busy),
    .ind_i       (ind),
    .ai_i        (ai),
    .mem_rdata_i (mem_rdata_i),
    .wr_mode_o   (wr_mode),
    .wr_hi_o     (wr_hi),
    .wr_lo_o     (wr_lo),
    .step_o      (step),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .rdata_o     (host_rdata_o)
  );

  assign mem_addr_o   = addr;
  assign mem_wdata_o  = host_wdata_i;
  assign soft_rst_o   = busy;
  assign ping_block_o = pb;
endmodule

// File: tb/sim_idx_access_bridge.sv
`timescale 1ns/100ps
module sim_idx_access_bridge;
  localparam int RSTC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [1:0] off = 2'd0;
  logic [7:0] wd = 8'h00, rd, mwd, mrd;
  logic [15:0] ma;
  logic mre, mwe, srst, pbo;

  int checks = 0, errors = 0;
  logic [7:0] rd_s, mwd_s;
  logic [15:0] ma_s;
  logic mre_s, mwe_s, srst_s, pb_s;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign mrd = pat(ma);

  idx_access_bridge #(.ADDR_W(16), .RST_CYCLES(RSTC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_sel_i(sel), .host_wr_i(wr),
    .host_off_i(off), .host_wdata_i(wd), .host_rdata_o(rd),
    .mem_addr_o(ma), .mem_re_o(mre), .mem_we_o(mwe), .mem_wdata_o(mwd),
    .mem_rdata_i(mrd), .soft_rst_o(srst), .ping_block_o(pbo));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic op(input bit w, input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = w; off = o; wd = d;
    #1;
    rd_s = rd; ma_s = ma; mre_s = mre; mwe_s = mwe; mwd_s = mwd;
    srst_s = srst; pb_s = pbo;
    @(posedge clk);
    #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    op(1'b1, 2'd1, a[15:8]);
    op(1'b1, 2'd2, a[7:0]);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2: reset state
    op(1'b0, 2'd0, 8'h00);
    chk(rd_s == 8'h00, "R2 mode", rd_s, 0);
    chk(!srst_s && !pb_s, "R2 outputs", {srst_s, pb_s}, 0);

    // R9: pointer access off
    op(1'b1, 2'd1, 8'h12);
    op(1'b1, 2'd3, 8'h77);
    chk(!mwe_s && !mre_s, "R9 no strobe", {mwe_s, mre_s}, 0);
    for (int o = 1; o < 4; o++) begin
      op(1'b0, 2'(o), 8'h00);
      chk(rd_s == 8'h00 && !mre_s, "R9 read zero", rd_s, 0);
    end
    op(1'b1, 2'd0, 8'h01);
    op(1'b0, 2'd1, 8'h00);
    chk(rd_s == 8'h00, "R9 write ignored", rd_s, 0);

    // R1, R12: mode readback
    op(1'b1, 2'd0, 8'hFF & 8'h7F);
    op(1'b0, 2'd0, 8'h00);
    chk(rd_s == 8'h13, "R1 mode bits", rd_s, 8'h13);
    chk(pb_s == 1'b1, "R12 ping on", pb_s, 1);
    op(1'b1, 2'd0, 8'h01);
    op(1'b0, 2'd0, 8'h00);
    chk(rd_s == 8'h01 && pb_s == 1'b0, "R12 ping off", rd_s, 1);

    // R3, R5, R7
    set_ptr(16'hABCD);
    op(1'b0, 2'd1, 8'h00);
    chk(rd_s == 8'hAB, "R3 high", rd_s, 8'hAB);
    op(1'b0, 2'd2, 8'h00);
    chk(rd_s == 8'hCD, "R3 low", rd_s, 8'hCD);
    for (int i = 0; i < 3; i++) begin
      op(1'b0, 2'd3, 8'h00);
      chk(mre_s && ma_s == 16'hABCD, "R7 hold addr", ma_s, 16'hABCD);
      chk(rd_s == pat(16'hABCD), "R5 read data", rd_s, pat(16'hABCD));
    end
    op(1'b1, 2'd3, 8'h3C);
    chk(mwe_s && ma_s == 16'hABCD && mwd_s == 8'h3C, "R4 single write", ma_s, 16'hABCD);
    op(1'b0, 2'd2, 8'h00);
    chk(rd_s == 8'hCD, "R7 after access", rd_s, 8'hCD);

    // R6: streaming reads
    op(1'b1, 2'd0, 8'h03);
    base = 16'h0100;
    set_ptr(base);
    for (int i = 0; i < 256; i++) begin
      op(1'b0, 2'd3, 8'h00);
      chk(mre_s && ma_s == base + 16'(i) && rd_s == pat(base + 16'(i)),
          "R6 stream read", ma_s, base + 16'(i));
    end

    // R4 with R6: streaming writes
    base = 16'h2000;
    set_ptr(base);
    for (int i = 0; i < 64; i++) begin
      op(1'b1, 2'd3, 8'(i * 7 + 1));
      chk(mwe_s && !mre_s && ma_s == base + 16'(i) && mwd_s == 8'(i * 7 + 1),
          "R4 stream write", ma_s, base + 16'(i));
    end
    op(1'b0, 2'd2, 8'h00);
    chk(rd_s == 8'h40, "R6 pointer after writes", rd_s, 8'h40);

    // R8: wrap
    set_ptr(16'hFFFE);
    for (int i = 0; i < 4; i++) begin
      op(1'b0, 2'd3, 8'h00);
      chk(ma_s == 16'(32'hFFFE + i) && rd_s == pat(16'(32'hFFFE + i)),
          "R8 wrap", ma_s, 16'(32'hFFFE + i));
    end

    // R10, R11: software reset
    set_ptr(16'h4321);
    op(1'b1, 2'd0, 8'h93);
    for (int i = 0; i < RSTC; i++) begin
      if (i == 1) begin
        op(1'b1, 2'd0, 8'h03);
        chk(srst_s, "R11 write during reset", srst_s, 1);
      end else if (i == 2) begin
        op(1'b1, 2'd1, 8'h55);
        chk(srst_s, "R11 ptr write during reset", srst_s, 1);
      end else begin
        op(1'b0, 2'd0, 8'h00);
        chk(srst_s && rd_s == 8'h80, "R10 busy mode", rd_s, 8'h80);
      end
    end
    op(1'b0, 2'd0, 8'h00);
    chk(!srst_s && rd_s == 8'h00, "R10 reset done", rd_s, 0);
    chk(!pb_s, "R10 ping cleared", pb_s, 0);
    op(1'b1, 2'd0, 8'h01);
    op(1'b0, 2'd1, 8'h00);
    chk(rd_s == 8'h00, "R10 ptr high cleared", rd_s, 0);
    op(1'b0, 2'd2, 8'h00);
    chk(rd_s == 8'h00, "R10 ptr low cleared", rd_s, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule